// File: doc/BRIEF.md
# LIN Header Transmit Sequencer

This block sits in front of a serial transmit line and turns one data write into either a plain character or a LIN host header. Software first strobes a two-bit command, then writes a byte. In normal operation the byte goes out as one asynchronous character. With the break command only a break field is sent and the written byte is discarded. With the header command the block sends a break field, then the synchronisation character, then the written byte as the frame identifier, all from that single write.

The command is a one-shot strobe. It is held internally only until the next data write uses it, and its read-back port always returns zero. It only takes effect while the host-mode qualifier is high. A byte written while a transfer is in flight waits in a single pending slot, together with the mode it was written under. Bit timing comes from an external one-cycle bit-tick pulse.

Top module: `lin_hdr_tx_seq`

## Requirements
- R1: With command code 0 (or no command armed), a data write sends one character on `txd`. The character is a low start bit, the DATA_W data bits least significant first, and a high stop bit, each one bit-time long.
- R2: With command code 1 and `host_mode` high, a data write sends BREAK_BITS (13) bit-times low, then DELIM_BITS (1) bit-time high, and nothing more. The written byte is not sent.
- R3: With command code 2 and `host_mode` high, a data write sends the break and delimiter, then the character 0x55, then the written byte as a character.
- R4: Command code 3 is reserved. A data write under it is sent exactly as under code 0.
- R5: While `host_mode` is low, any armed command is treated as code 0.
- R6: `cmd_rdata` always reads zero. An armed command applies to exactly one following data write, and later writes revert to code 0.
- R7: When `cmd_wr` and `data_wr` are asserted in the same cycle, the command written in that cycle governs that data write.
- R8: `busy` rises on the clock edge that follows the cycle in which `data_wr` is asserted. It falls on the edge that ends the last bit of the sequence, provided nothing is pending. While `busy` is low, `txd` is high.
- R9: A data write while a sequence is running is held in one pending slot with its resolved mode, and is sent right after the current sequence. Further writes while the slot is full are dropped.
- R10: While a sequence runs, `txd` changes only on a clock edge at which `bit_tick` was high.
- R11: After reset, `txd` is high and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_mode | input | 1 | High when the link is configured as host, which enables the command field |
| cmd_wr | input | 1 | Command strobe write |
| cmd_wdata | input | 2 | Command code: 0 normal, 1 break only, 2 full header, 3 reserved |
| cmd_rdata | output | 2 | Command read-back, always zero |
| data_wr | input | 1 | Data register write |
| data_wdata | input | DATA_W | Byte to send (the identifier in header mode) |
| bit_tick | input | 1 | One-cycle pulse marking the end of each bit-time |
| txd | output | 1 | Serial transmit line, idle high |
| busy | output | 1 | High while a sequence is running or a write is pending |

## Verification
The hardest case to reach is a pending write that carries an armed header command. It must be queued while a plain character is still shifting out, and it must launch on the same edge that ends that character's stop bit. The stimulus first starts a plain character. Partway through that character it strobes the header command and writes a second byte. It then writes a third byte while the slot is full. The scoreboard expects the character followed directly by the complete header, with no bits from the dropped write.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

  // Command codes seen on the strobe port
  localparam logic [1:0] CMD_NORMAL = 2'd0;
  localparam logic [1:0] CMD_BREAK  = 2'd1;
  localparam logic [1:0] CMD_HEADER = 2'd2;

  typedef enum logic [1:0] {
    SEQ_NORMAL = 2'd0,
    SEQ_BREAK  = 2'd1,
    SEQ_HEADER = 2'd2
  } seq_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_BREAK = 3'd1,
    PH_DELIM = 3'd2,
    PH_SYNC  = 3'd3,
    PH_CHAR  = 3'd4
  } phase_e;

  // Map a command code to a sequence mode; reserved and non-host give normal
  function automatic seq_mode_e resolve_mode(input logic host, input logic [1:0] cmd);
    if (!host)              return SEQ_NORMAL;
    else if (cmd == CMD_BREAK)  return SEQ_BREAK;
    else if (cmd == CMD_HEADER) return SEQ_HEADER;
    else                        return SEQ_NORMAL;
  endfunction

endpackage

// File: rtl/lin_cmd_arm.sv
module lin_cmd_arm
  import lin_hdr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      host_mode,
  input  logic      cmd_wr,
  input  logic [1:0] cmd_val,
  input  logic      consume,
  output seq_mode_e eff_mode
);

  logic [1:0] armed_q;
  logic [1:0] eff_cmd;

  // A command written in the same cycle as the data write wins
  assign eff_cmd  = cmd_wr ? cmd_val : armed_q;
  assign eff_mode = resolve_mode(host_mode, eff_cmd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed_q <= CMD_NORMAL;
    else if (consume) armed_q <= CMD_NORMAL;
    else if (cmd_wr)  armed_q <= cmd_val;
  end

endmodule

// File: rtl/lin_pend_slot.sv
module lin_pend_slot
  import lin_hdr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  seq_mode_e         load_mode,
  input  logic              take,
  output logic              valid,
  output logic [DATA_W-1:0] held_byte,
  output seq_mode_e         held_mode
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid     <= 1'b0;
      held_byte <= '0;
      held_mode <= SEQ_NORMAL;
    end else if (load) begin
      valid     <= 1'b1;
      held_byte <= load_byte;
      held_mode <= load_mode;
    end else if (take) begin
      valid     <= 1'b0;
    end
  end

endmodule

// File: rtl/lin_bit_seq.sv
module lin_bit_seq
  import lin_hdr_pkg::*;
#(
  parameter int              DATA_W     = 8,
  parameter int              BREAK_BITS = 13,
  parameter int              DELIM_BITS = 1,
  parameter logic [DATA_W-1:0] SYNC_PAT = 'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              launch,
  input  seq_mode_e         launch_mode,
  input  logic [DATA_W-1:0] launch_byte,
  output logic              txd,
  output logic              seq_busy,
  output logic              seq_done,
  output logic              in_break
);

  localparam int CHAR_BITS = DATA_W + 2;
  localparam int MAX_SEG   = (BREAK_BITS > CHAR_BITS) ?
                             ((BREAK_BITS > DELIM_BITS) ? BREAK_BITS : DELIM_BITS) :
                             ((CHAR_BITS > DELIM_BITS) ? CHAR_BITS : DELIM_BITS);
  localparam int CNT_W     = $clog2(MAX_SEG + 1);

  phase_e            phase_q;
  seq_mode_e         mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] byte_q;
  logic              last_bit;
  phase_e            phase_after;

  // Number of bit-times in a segment
  function automatic int seg_len(input phase_e ph);
    case (ph)
      PH_BREAK: return BREAK_BITS;
      PH_DELIM: return DELIM_BITS;
      PH_SYNC,
      PH_CHAR:  return CHAR_BITS;
      default:  return 1;
    endcase
  endfunction

  // Level of bit number idx within an asynchronous character
  function automatic logic char_bit(input logic [DATA_W-1:0] b, input int idx);
    if (idx == 0)           return 1'b0;
    else if (idx <= DATA_W) return b[idx-1];
    else                    return 1'b1;
  endfunction

  assign last_bit = (phase_q != PH_IDLE) && (int'(cnt_q) == seg_len(phase_q) - 1);

  always_comb begin
    case (phase_q)
      PH_BREAK: phase_after = PH_DELIM;
      PH_DELIM: phase_after = (mode_q == SEQ_HEADER) ? PH_SYNC : PH_IDLE;
      PH_SYNC:  phase_after = PH_CHAR;
      default:  phase_after = PH_IDLE;
    endcase
  end

  assign seq_busy = (phase_q != PH_IDLE);
  assign seq_done = bit_tick && last_bit && (phase_after == PH_IDLE);
  assign in_break = (phase_q == PH_BREAK);

  always_comb begin
    case (phase_q)
      PH_BREAK: txd = 1'b0;
      PH_DELIM: txd = 1'b1;
      PH_SYNC:  txd = char_bit(SYNC_PAT, int'(cnt_q));
      PH_CHAR:  txd = char_bit(byte_q, int'(cnt_q));
      default:  txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      mode_q  <= SEQ_NORMAL;
      cnt_q   <= '0;
      byte_q  <= '0;
    end else if (launch) begin
      phase_q <= (launch_mode == SEQ_NORMAL) ? PH_CHAR : PH_BREAK;
      mode_q  <= launch_mode;
      cnt_q   <= '0;
      byte_q  <= launch_byte;
    end else if (bit_tick && seq_busy) begin
      if (last_bit) begin
        phase_q <= phase_after;
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lin_hdr_tx_seq.sv
module lin_hdr_tx_seq
  import lin_hdr_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BREAK_BITS = 13,
  parameter int DELIM_BITS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_mode,
  input  logic              cmd_wr,
  input  logic [1:0]        cmd_wdata,
  output logic [1:0]        cmd_rdata,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_wdata,
  input  logic              bit_tick,
  output logic              txd,
  output logic              busy
);

  seq_mode_e         wr_mode;
  seq_mode_e         pend_mode;
  seq_mode_e         launch_mode;
  logic [DATA_W-1:0] pend_byte;
  logic [DATA_W-1:0] launch_byte;
  logic              pend_valid;
  logic              seq_busy;
  logic              seq_done;
  logic              in_break;
  logic              seq_free;
  logic              launch_pend;
  logic              launch_direct;
  logic              launch;
  logic              pend_load;

  // Strobe field never holds a readable value
  assign cmd_rdata = 2'b00;

  lin_cmd_arm u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_mode (host_mode),
    .cmd_wr    (cmd_wr),
    .cmd_val   (cmd_wdata),
    .consume   (data_wr),
    .eff_mode  (wr_mode)
  );

  assign seq_free      = !seq_busy || seq_done;
  assign launch_pend   = pend_valid && seq_free;
  assign launch_direct = data_wr && seq_free && !pend_valid;
  assign launch        = launch_pend || launch_direct;
  assign pend_load     = data_wr && !seq_free && !pend_valid;
  assign launch_mode   = launch_pend ? pend_mode : wr_mode;
  assign launch_byte   = launch_pend ? pend_byte : data_wdata;

  lin_pend_slot #(.DATA_W(DATA_W)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (pend_load),
    .load_byte (data_wdata),
    .load_mode (wr_mode),
    .take      (launch_pend),
    .valid     (pend_valid),
    .held_byte (pend_byte),
    .held_mode (pend_mode)
  );

  lin_bit_seq #(
    .DATA_W     (DATA_W),
    .BREAK_BITS (BREAK_BITS),
    .DELIM_BITS (DELIM_BITS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .launch      (launch),
    .launch_mode (launch_mode),
    .launch_byte (launch_byte),
    .txd         (txd),
    .seq_busy    (seq_busy),
    .seq_done    (seq_done),
    .in_break    (in_break)
  );

  assign busy = seq_busy || pend_valid;

endmodule

// File: rtl/lin_hdr_tx_seq_chk.sv
module lin_hdr_tx_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic busy,
  input logic bit_tick,
  input logic data_wr,
  input logic seq_busy,
  input logic seq_done,
  input logic in_break,
  input logic pend_valid,
  input logic pend_load,
  input logic launch
);

  a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  a_r2_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    in_break |-> !txd);

  a_r10_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && !bit_tick) |=> $stable(txd));

  a_r10_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> bit_tick);

  a_r8_busy_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  a_r8_drop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !pend_valid && !data_wr) |=> !busy);

  a_r9_slot_fills: assert property (@(posedge clk) disable iff (!rst_n)
    pend_load |=> pend_valid);

  a_r9_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && seq_busy && !seq_done) |=> pend_valid);

endmodule

bind lin_hdr_tx_seq lin_hdr_tx_seq_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .txd        (txd),
  .busy       (busy),
  .bit_tick   (bit_tick),
  .data_wr    (data_wr),
  .seq_busy   (seq_busy),
  .seq_done   (seq_done),
  .in_break   (in_break),
  .pend_valid (pend_valid),
  .pend_load  (pend_load),
  .launch     (launch)
);

// File: tb/lin_hdr_tx_seq_tb_top.sv
module lin_hdr_tx_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_mode;
  logic       cmd_wr;
  logic [1:0] cmd_wdata;
  logic [1:0] cmd_rdata;
  logic       data_wr;
  logic [7:0] data_wdata;
  logic       bit_tick;
  logic       txd;
  logic       busy;

  always #5 clk = ~clk;

  lin_hdr_tx_seq dut_i (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .data_wr(data_wr), .data_wdata(data_wdata),
    .bit_tick(bit_tick), .txd(txd), .busy(busy)
  );

  int    checks = 0;
  int    errors = 0;
  logic  exp_bit[$];
  string exp_tag[$];
  logic  idle_due = 1'b0;
  logic  prev_busy = 1'b0, prev_tick = 1'b0, prev_txd = 1'b1;

  task automatic check(input logic ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Scoreboard producers
  task automatic push_char(input logic [7:0] b, input string tag);
    exp_bit.push_back(1'b0); exp_tag.push_back(tag);
    for (int i = 0; i < 8; i++) begin
      exp_bit.push_back(b[i]); exp_tag.push_back(tag);
    end
    exp_bit.push_back(1'b1); exp_tag.push_back(tag);
  endtask

  task automatic push_break(input string tag);
    for (int i = 0; i < 13; i++) begin
      exp_bit.push_back(1'b0); exp_tag.push_back(tag);
    end
    exp_bit.push_back(1'b1); exp_tag.push_back(tag);
  endtask

  task automatic push_header(input logic [7:0] id, input string tag);
    push_break(tag);
    push_char(8'h55, tag);
    push_char(id, tag);
  endtask

  // Drivers: change inputs 1 ns after the rising edge
  task automatic wr_cmd(input logic [1:0] c);
    @(posedge clk); #1 cmd_wr = 1'b1; cmd_wdata = c;
    @(posedge clk); #1 cmd_wr = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] d);
    @(posedge clk); #1 data_wr = 1'b1; data_wdata = d;
    @(posedge clk); #1 data_wr = 1'b0;
  endtask

  task automatic wr_both(input logic [1:0] c, input logic [7:0] d);
    @(posedge clk); #1 cmd_wr = 1'b1; cmd_wdata = c; data_wr = 1'b1; data_wdata = d;
    @(posedge clk); #1 cmd_wr = 1'b0; data_wr = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_bit.size() == 0, tag, "bits still owed", exp_bit.size(), 0);
  endtask

  // Bit-time generator: one pulse every 8 cycles
  initial begin
    bit_tick = 1'b0;
    @(posedge rst_n);
    forever begin
      repeat (7) @(posedge clk);
      #1 bit_tick = 1'b1;
      @(posedge clk);
      #1 bit_tick = 1'b0;
    end
  end

  // Monitor: compare txd at each bit end against the queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (idle_due) begin
        check(!busy, "R8", "busy after last bit", busy, 0);
        idle_due = 1'b0;
      end
      if (prev_busy && busy && !prev_tick)
        check(txd == prev_txd, "R10", "txd moved without tick", txd, prev_txd);
      if (bit_tick && busy) begin
        if (exp_bit.size() == 0) begin
          check(1'b0, "R9", "unexpected bit", txd, 1);
        end else begin
          logic  e;
          string t;
          e = exp_bit.pop_front();
          t = exp_tag.pop_front();
          check(txd == e, t, "txd bit", txd, e);
          if (exp_bit.size() == 0) idle_due = 1'b1;
        end
      end
      prev_busy = busy;
      prev_tick = bit_tick;
      prev_txd  = txd;
    end
  end

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R8 watchdog expired actual=busy expected=idle");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; host_mode = 1'b1; cmd_wr = 1'b0; cmd_wdata = 2'd0;
    data_wr = 1'b0; data_wdata = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(txd == 1'b1, "R11", "txd in reset", txd, 1);
    check(busy == 1'b0, "R11", "busy in reset", busy, 0);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(txd == 1'b1 && !busy, "R11", "idle after reset", {busy, txd}, 1);

    // R1: plain character, also busy start timing for R8
    push_char(8'hA5, "R1");
    wr_data(8'hA5);
    @(negedge clk);
    check(busy == 1'b1, "R8", "busy after write", busy, 1);
    wait_idle("R1");

    // R2: break only, byte discarded
    wr_cmd(2'd1);
    push_break("R2");
    wr_data(8'h3C);
    wait_idle("R2");

    // R3: break, sync, identifier
    wr_cmd(2'd2);
    @(negedge clk);
    check(cmd_rdata == 2'd0, "R6", "command readback", cmd_rdata, 0);
    push_header(8'h17, "R3");
    wr_data(8'h17);
    wait_idle("R3");

    // R6: command was consumed, next write is plain
    push_char(8'h99, "R6");
    wr_data(8'h99);
    wait_idle("R6");

    // R4: reserved code acts as normal
    wr_cmd(2'd3);
    push_char(8'h81, "R4");
    wr_data(8'h81);
    wait_idle("R4");

    // R5: header command ignored outside host mode
    host_mode = 1'b0;
    wr_cmd(2'd2);
    push_char(8'h42, "R5");
    wr_data(8'h42);
    wait_idle("R5");
    host_mode = 1'b1;

    // R7: command and data in the same cycle
    push_break("R7");
    wr_both(2'd1, 8'hF0);
    wait_idle("R7");

    // R9: pending write with header command, then a dropped write
    push_char(8'h11, "R9");
    wr_data(8'h11);
    repeat (20) @(posedge clk);
    wr_cmd(2'd2);
    push_header(8'h22, "R9");
    wr_data(8'h22);
    @(negedge clk);
    check(busy == 1'b1, "R9", "busy with slot full", busy, 1);
    wr_data(8'h33);
    wait_idle("R9");

    finish_run();
  end

endmodule